// File: doc/BRIEF.md
# Message Buffer Slot Search Engine

This block picks, for one slot of a communication cycle, which message buffer each of two bus channels (A and B) will use. It walks a parameterised bank of buffer configurations one entry per clock. For every buffer it checks three things: that the buffer is switched on, that its slot ID equals the slot being searched, and that its cycle filter accepts the current cycle count. The candidates that remain go into a priority pick that is run separately for each channel.

A search begins with a one-cycle start pulse. At that pulse the block captures the slot number, the cycle count and the static-segment flag. When the scan is complete it pulses `done`. Each channel then has a found flag, the winning buffer index and a null-frame flag. A transmit buffer in the static segment whose filter rejects the cycle still wins its slot, and it is flagged so that a null frame goes out in place of its data. A consistency flag reports a mix of single-channel and dual-channel buffers at the winning priority.

The buffer configuration vectors must stay stable from the start pulse until `done`.

Top module: `mb_slot_search`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `done`, `busy`, `a_found`, `b_found`, `a_null`, `b_null` and `cons_err` are 0, and `a_idx` and `b_idx` are 0.
- R2: A `start` sampled while `busy` is 0 sets `busy` at that edge. It clears `busy` and raises `done` for exactly one cycle NUM_BUF edges later. A `start` sampled while `busy` is 1 has no effect.
- R3: A buffer whose filter-enable bit is 0 matches every cycle count 0 to 63.
- R4: A buffer whose filter-enable bit is 1 matches only when (cycle AND mask) equals (value AND mask). All three of these are 6-bit values.
- R5: A buffer is never a candidate if its enable bit is 0 or if its slot ID differs from the slot captured at start.
- R6: A lower priority value means higher priority. A channel's winner is the candidate with the smallest priority value, and ties go to the lowest index. When a channel has no candidate, its found flag is 0 and its index is 0.
- R7: Only buffers with the channel-A bit set take part in the A search, and only buffers with the channel-B bit set take part in the B search. A buffer with both bits set can win both searches.
- R8: When the static flag is captured as 1, a transmit buffer (`buf_tx` bit 1) whose filter fails is still a candidate, and if it wins, that channel's null flag is 1. A receive buffer whose filter fails is never a candidate. When the static flag is 0, every buffer whose filter fails is excluded. The null flag is 0 whenever the winner's filter matched.
- R9: `cons_err` is 1 when, for at least one channel with a winner, the candidates at the winning priority include both a single-channel buffer (exactly one channel bit set) and a dual-channel buffer (both channel bits set).
- R10: The result outputs change only at the edge that raises `done`, and they hold until the next search completes. The slot, cycle and static inputs are used as captured at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (ignored while busy) |
| cur_slot | input | SLOT_W | Slot number to search |
| cyc_cnt | input | 6 | Current communication cycle count |
| static_seg | input | 1 | Slot lies in the static segment |
| buf_en | input | NUM_BUF | Per-buffer enable |
| buf_slot | input | NUM_BUF*SLOT_W | Per-buffer slot ID, buffer i at bits [i*SLOT_W +: SLOT_W] |
| buf_tx | input | NUM_BUF | Per-buffer type, 1 = transmit, 0 = receive |
| buf_prio | input | NUM_BUF*PRIO_W | Per-buffer priority, buffer i at [i*PRIO_W +: PRIO_W] |
| buf_cfe | input | NUM_BUF | Per-buffer cycle-filter enable |
| buf_cmask | input | NUM_BUF*6 | Per-buffer filter mask, buffer i at [i*6 +: 6] |
| buf_cval | input | NUM_BUF*6 | Per-buffer filter value, buffer i at [i*6 +: 6] |
| buf_cha | input | NUM_BUF | Per-buffer channel-A assignment |
| buf_chb | input | NUM_BUF | Per-buffer channel-B assignment |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| a_found | output | 1 | Channel A has a winner |
| a_idx | output | IDX_W | Channel A winning buffer |
| a_null | output | 1 | Channel A winner must send a null frame |
| b_found | output | 1 | Channel B has a winner |
| b_idx | output | IDX_W | Channel B winning buffer |
| b_null | output | 1 | Channel B winner must send a null frame |
| cons_err | output | 1 | Mixed channel assignment at a winning priority |

## Verification
The search of channel A and the search of channel B run in the same scan and can settle on the same buffer. Any candidate in either channel can also turn out to be a null-frame claim. Directed cases put one dual-channel buffer at the top priority on both channels. Other cases place a static transmit buffer with a failing filter above a matching receive buffer, and build a mixed single/dual tie. A pseudo-random series then fills a few slots with overlapping assignments. A behavioural model in the bench picks the winners in two passes, first the best priority and then the lowest index. It is compared with every output on every clock, so a result that appears a cycle early or late also counts as a mismatch.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    localparam int CYC_W = 6;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    // Per-buffer verdict produced by the evaluator for the current scan step.
    typedef struct packed {
        logic cand_a;
        logic cand_b;
        logic dual;
        logic null_tx;
    } buf_verdict_t;

    // Value/mask comparison of the cycle count against one buffer's filter.
    function automatic logic cyc_filter_hit(
        input logic             fe,
        input logic [CYC_W-1:0] mask,
        input logic [CYC_W-1:0] val,
        input logic [CYC_W-1:0] cyc
    );
        return (!fe) || ((cyc & mask) == (val & mask));
    endfunction

endpackage

// File: rtl/mbs_scan_ctrl.sv
module mbs_scan_ctrl
    import mbs_pkg::*;
#(
    parameter int NUM_BUF = 16,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             clear,
    output logic             step,
    output logic             last,
    output logic [IDX_W-1:0] idx,
    output logic             busy,
    output logic             done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BUF - 1);

    scan_state_e      state_q;
    logic [IDX_W-1:0] cnt_q;
    logic             done_q;

    assign clear = (state_q == ST_IDLE) && start;
    assign step  = (state_q == ST_SCAN);
    assign last  = step && (cnt_q == LAST_IDX);
    assign idx   = cnt_q;
    assign busy  = step;
    assign done  = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_SCAN;
                        cnt_q   <= '0;
                    end
                end
                ST_SCAN: begin
                    if (cnt_q == LAST_IDX) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mbs_buf_eval.sv
module mbs_buf_eval
    import mbs_pkg::*;
#(
    parameter int SLOT_W = 11
) (
    input  logic              en,
    input  logic [SLOT_W-1:0] slot,
    input  logic [SLOT_W-1:0] want_slot,
    input  logic              tx,
    input  logic              cfe,
    input  logic [CYC_W-1:0]  cmask,
    input  logic [CYC_W-1:0]  cval,
    input  logic [CYC_W-1:0]  cyc,
    input  logic              in_static,
    input  logic              cha,
    input  logic              chb,
    output buf_verdict_t      verdict
);

    logic slot_hit;
    logic flt_hit;
    logic claims;

    always_comb begin
        slot_hit = en && (slot == want_slot);
        flt_hit  = cyc_filter_hit(cfe, cmask, cval, cyc);
        // Static transmit buffers keep their slot even when the filter rejects.
        claims   = flt_hit || (tx && in_static);

        verdict.cand_a  = slot_hit && claims && cha;
        verdict.cand_b  = slot_hit && claims && chb;
        verdict.dual    = cha && chb;
        verdict.null_tx = !flt_hit;
    end

endmodule

// File: rtl/mbs_chan_track.sv
module mbs_chan_track #(
    parameter int IDX_W  = 4,
    parameter int PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    input  logic              last,
    input  logic              cand,
    input  logic [PRIO_W-1:0] prio,
    input  logic [IDX_W-1:0]  idx,
    input  logic              null_in,
    input  logic              dual_in,
    output logic              found_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              null_o,
    output logic              mix_o
);

    typedef struct packed {
        logic              found;
        logic [PRIO_W-1:0] prio;
        logic [IDX_W-1:0]  idx;
        logic              nul;
        logic              seen_single;
        logic              seen_dual;
    } track_t;

    track_t cur_q;
    track_t nxt;

    always_comb begin
        nxt = cur_q;
        if (cand) begin
            if (!cur_q.found || (prio < cur_q.prio)) begin
                nxt.found       = 1'b1;
                nxt.prio        = prio;
                nxt.idx         = idx;
                nxt.nul         = null_in;
                nxt.seen_single = !dual_in;
                nxt.seen_dual   = dual_in;
            end else if (prio == cur_q.prio) begin
                // Equal priority: earlier index keeps the win, only record the kind.
                nxt.seen_single = cur_q.seen_single || !dual_in;
                nxt.seen_dual   = cur_q.seen_dual || dual_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            found_o <= 1'b0;
            idx_o   <= '0;
            null_o  <= 1'b0;
            mix_o   <= 1'b0;
        end else begin
            if (clear) begin
                cur_q <= '0;
            end else if (step) begin
                cur_q <= nxt;
            end
            if (step && last) begin
                found_o <= nxt.found;
                idx_o   <= nxt.idx;
                null_o  <= nxt.found && nxt.nul;
                mix_o   <= nxt.found && nxt.seen_single && nxt.seen_dual;
            end
        end
    end

endmodule

// File: rtl/mb_slot_search.sv
module mb_slot_search
    import mbs_pkg::*;
#(
    parameter int NUM_BUF = 16,
    parameter int SLOT_W  = 11,
    parameter int PRIO_W  = 4,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [SLOT_W-1:0]         cur_slot,
    input  logic [CYC_W-1:0]          cyc_cnt,
    input  logic                      static_seg,
    input  logic [NUM_BUF-1:0]        buf_en,
    input  logic [NUM_BUF*SLOT_W-1:0] buf_slot,
    input  logic [NUM_BUF-1:0]        buf_tx,
    input  logic [NUM_BUF*PRIO_W-1:0] buf_prio,
    input  logic [NUM_BUF-1:0]        buf_cfe,
    input  logic [NUM_BUF*CYC_W-1:0]  buf_cmask,
    input  logic [NUM_BUF*CYC_W-1:0]  buf_cval,
    input  logic [NUM_BUF-1:0]        buf_cha,
    input  logic [NUM_BUF-1:0]        buf_chb,
    output logic                      busy,
    output logic                      done,
    output logic                      a_found,
    output logic [IDX_W-1:0]          a_idx,
    output logic                      a_null,
    output logic                      b_found,
    output logic [IDX_W-1:0]          b_idx,
    output logic                      b_null,
    output logic                      cons_err
);

    localparam int N_CHAN = 2;

    logic             clear;
    logic             step;
    logic             last;
    logic [IDX_W-1:0] scan_idx;

    logic [SLOT_W-1:0] slot_q;
    logic [CYC_W-1:0]  cyc_q;
    logic              static_q;

    logic [SLOT_W-1:0] sel_slot;
    logic [PRIO_W-1:0] sel_prio;
    logic [CYC_W-1:0]  sel_mask;
    logic [CYC_W-1:0]  sel_val;
    logic              sel_en;
    logic              sel_tx;
    logic              sel_cfe;
    logic              sel_cha;
    logic              sel_chb;

    buf_verdict_t verdict;

    logic [N_CHAN-1:0] ch_cand;
    logic [N_CHAN-1:0] ch_found;
    logic [N_CHAN-1:0] ch_null;
    logic [N_CHAN-1:0] ch_mix;
    logic [IDX_W-1:0]  ch_idx [N_CHAN];

    mbs_scan_ctrl #(
        .NUM_BUF(NUM_BUF)
    ) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .clear(clear),
        .step (step),
        .last (last),
        .idx  (scan_idx),
        .busy (busy),
        .done (done)
    );

    // Capture the search context at the accepted start pulse.
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= '0;
            cyc_q    <= '0;
            static_q <= 1'b0;
        end else if (clear) begin
            slot_q   <= cur_slot;
            cyc_q    <= cyc_cnt;
            static_q <= static_seg;
        end
    end

    // Select the configuration of the buffer under scan.
    always_comb begin
        sel_slot = buf_slot [int'(scan_idx)*SLOT_W +: SLOT_W];
        sel_prio = buf_prio [int'(scan_idx)*PRIO_W +: PRIO_W];
        sel_mask = buf_cmask[int'(scan_idx)*CYC_W  +: CYC_W];
        sel_val  = buf_cval [int'(scan_idx)*CYC_W  +: CYC_W];
        sel_en   = buf_en [scan_idx];
        sel_tx   = buf_tx [scan_idx];
        sel_cfe  = buf_cfe[scan_idx];
        sel_cha  = buf_cha[scan_idx];
        sel_chb  = buf_chb[scan_idx];
    end

    mbs_buf_eval #(
        .SLOT_W(SLOT_W)
    ) u_eval (
        .en       (sel_en),
        .slot     (sel_slot),
        .want_slot(slot_q),
        .tx       (sel_tx),
        .cfe      (sel_cfe),
        .cmask    (sel_mask),
        .cval     (sel_val),
        .cyc      (cyc_q),
        .in_static(static_q),
        .cha      (sel_cha),
        .chb      (sel_chb),
        .verdict  (verdict)
    );

    assign ch_cand = {verdict.cand_b, verdict.cand_a};

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        mbs_chan_track #(
            .IDX_W (IDX_W),
            .PRIO_W(PRIO_W)
        ) u_track (
            .clk    (clk),
            .rst    (rst),
            .clear  (clear),
            .step   (step),
            .last   (last),
            .cand   (ch_cand[c]),
            .prio   (sel_prio),
            .idx    (scan_idx),
            .null_in(verdict.null_tx),
            .dual_in(verdict.dual),
            .found_o(ch_found[c]),
            .idx_o  (ch_idx[c]),
            .null_o (ch_null[c]),
            .mix_o  (ch_mix[c])
        );
    end

    assign a_found  = ch_found[0];
    assign a_idx    = ch_idx[0];
    assign a_null   = ch_null[0];
    assign b_found  = ch_found[1];
    assign b_idx    = ch_idx[1];
    assign b_null   = ch_null[1];
    assign cons_err = |ch_mix;

endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
    parameter int NUM_BUF = 16,
    parameter int IDX_W   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             a_found,
    input logic [IDX_W-1:0] a_idx,
    input logic             a_null,
    input logic             b_found,
    input logic [IDX_W-1:0] b_idx,
    input logic             b_null,
    input logic             cons_err
);

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_idx_range_r6: assert property (@(posedge clk) disable iff (rst)
        (a_found |-> (int'(a_idx) < NUM_BUF)) and (b_found |-> (int'(b_idx) < NUM_BUF)));

    p_null_found_r8: assert property (@(posedge clk) disable iff (rst)
        (a_null |-> a_found) and (b_null |-> b_found));

    p_err_found_r9: assert property (@(posedge clk) disable iff (rst)
        cons_err |-> (a_found || b_found));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({a_found, a_idx, a_null, b_found, b_idx, b_null, cons_err}));

endmodule

bind mb_slot_search mbs_checker #(
    .NUM_BUF(NUM_BUF),
    .IDX_W  (IDX_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .a_found (a_found),
    .a_idx   (a_idx),
    .a_null  (a_null),
    .b_found (b_found),
    .b_idx   (b_idx),
    .b_null  (b_null),
    .cons_err(cons_err)
);

// File: tb/mb_slot_search_tb.sv
module mb_slot_search_tb;

    localparam int N      = 16;
    localparam int SLOT_W = 11;
    localparam int PRIO_W = 4;
    localparam int CW     = 6;
    localparam int IDX_W  = $clog2(N);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic              start = 1'b0;
    logic [SLOT_W-1:0] cur_slot = '0;
    logic [CW-1:0]     cyc_cnt = '0;
    logic              static_seg = 1'b0;

    logic              c_en   [N];
    logic [SLOT_W-1:0] c_slot [N];
    logic              c_tx   [N];
    logic [PRIO_W-1:0] c_prio [N];
    logic              c_cfe  [N];
    logic [CW-1:0]     c_mask [N];
    logic [CW-1:0]     c_val  [N];
    logic              c_cha  [N];
    logic              c_chb  [N];

    logic [N-1:0]        buf_en, buf_tx, buf_cfe, buf_cha, buf_chb;
    logic [N*SLOT_W-1:0] buf_slot;
    logic [N*PRIO_W-1:0] buf_prio;
    logic [N*CW-1:0]     buf_cmask, buf_cval;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            buf_en[i]  = c_en[i];
            buf_tx[i]  = c_tx[i];
            buf_cfe[i] = c_cfe[i];
            buf_cha[i] = c_cha[i];
            buf_chb[i] = c_chb[i];
            buf_slot [i*SLOT_W +: SLOT_W] = c_slot[i];
            buf_prio [i*PRIO_W +: PRIO_W] = c_prio[i];
            buf_cmask[i*CW +: CW] = c_mask[i];
            buf_cval [i*CW +: CW] = c_val[i];
        end
    end

    logic             busy, done, a_found, a_null, b_found, b_null, cons_err;
    logic [IDX_W-1:0] a_idx, b_idx;

    mb_slot_search #(.NUM_BUF(N), .SLOT_W(SLOT_W), .PRIO_W(PRIO_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .cur_slot(cur_slot), .cyc_cnt(cyc_cnt),
        .static_seg(static_seg), .buf_en(buf_en), .buf_slot(buf_slot), .buf_tx(buf_tx),
        .buf_prio(buf_prio), .buf_cfe(buf_cfe), .buf_cmask(buf_cmask), .buf_cval(buf_cval),
        .buf_cha(buf_cha), .buf_chb(buf_chb), .busy(busy), .done(done),
        .a_found(a_found), .a_idx(a_idx), .a_null(a_null),
        .b_found(b_found), .b_idx(b_idx), .b_null(b_null), .cons_err(cons_err)
    );

    int    total = 0;
    int    bad   = 0;
    string cur_req = "R1";

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    function automatic bit filt_ok(input int i, input logic [CW-1:0] cy);
        if (!c_cfe[i]) return 1'b1;
        return (cy & c_mask[i]) == (c_val[i] & c_mask[i]);
    endfunction

    function automatic bit is_cand(input int i, input logic [SLOT_W-1:0] s,
                                   input logic [CW-1:0] cy, input bit st, input bit chb);
        bit onch;
        onch = chb ? c_chb[i] : c_cha[i];
        return c_en[i] && (c_slot[i] == s) && onch && (filt_ok(i, cy) || (c_tx[i] && st));
    endfunction

    function automatic void ref_pick(input logic [SLOT_W-1:0] s, input logic [CW-1:0] cy,
                                     input bit st, input bit chb, output bit f, output int idx,
                                     output bit nl, output bit mix);
        int best;
        bit sgl;
        bit dul;
        best = 1 << PRIO_W;
        f = 0; idx = 0; nl = 0; mix = 0; sgl = 0; dul = 0;
        for (int i = 0; i < N; i++)
            if (is_cand(i, s, cy, st, chb) && int'(c_prio[i]) < best) best = int'(c_prio[i]);
        for (int i = N - 1; i >= 0; i--) begin
            if (is_cand(i, s, cy, st, chb) && int'(c_prio[i]) == best) begin
                f = 1; idx = i; nl = !filt_ok(i, cy);
                if (c_cha[i] && c_chb[i]) dul = 1; else sgl = 1;
            end
        end
        mix = f && sgl && dul;
    endfunction

    bit              m_busy = 0, m_done = 0;
    int              m_cnt = 0;
    logic [SLOT_W-1:0] m_slot;
    logic [CW-1:0]   m_cyc;
    bit              m_st;
    bit              ma_f = 0, ma_n = 0, mb_f = 0, mb_n = 0, m_err = 0;
    int              ma_i = 0, mb_i = 0;

    always @(posedge clk) begin
        bit ea, eb;
        if (rst) begin
            m_busy = 0; m_done = 0; m_cnt = 0;
            ma_f = 0; ma_n = 0; ma_i = 0; mb_f = 0; mb_n = 0; mb_i = 0; m_err = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == N) begin
                    m_busy = 0; m_done = 1;
                    ref_pick(m_slot, m_cyc, m_st, 1'b0, ma_f, ma_i, ma_n, ea);
                    ref_pick(m_slot, m_cyc, m_st, 1'b1, mb_f, mb_i, mb_n, eb);
                    m_err = ea || eb;
                end
            end else if (start) begin
                m_busy = 1; m_cnt = 0;
                m_slot = cur_slot; m_cyc = cyc_cnt; m_st = static_seg;
            end
        end
    end

    // Compare every output on every clock, away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2", "done", int'(done), int'(m_done));
            chk("R2", "busy", int'(busy), int'(m_busy));
            chk(cur_req, "a_found", int'(a_found), int'(ma_f));
            chk(cur_req, "a_idx", int'(a_idx), ma_i);
            chk(cur_req, "a_null", int'(a_null), int'(ma_n));
            chk(cur_req, "b_found", int'(b_found), int'(mb_f));
            chk(cur_req, "b_idx", int'(b_idx), mb_i);
            chk(cur_req, "b_null", int'(b_null), int'(mb_n));
            chk(cur_req, "cons_err", int'(cons_err), int'(m_err));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic clear_cfg();
        for (int i = 0; i < N; i++) begin
            c_en[i] = 0; c_slot[i] = '0; c_tx[i] = 0; c_prio[i] = '0; c_cfe[i] = 0;
            c_mask[i] = '0; c_val[i] = '0; c_cha[i] = 0; c_chb[i] = 0;
        end
    endtask

    task automatic set_buf(input int i, input int slot, input bit tx, input int prio,
                           input bit cfe, input int mask, input int val, input bit cha, input bit chb);
        c_en[i] = 1; c_slot[i] = SLOT_W'(slot); c_tx[i] = tx; c_prio[i] = PRIO_W'(prio);
        c_cfe[i] = cfe; c_mask[i] = CW'(mask); c_val[i] = CW'(val); c_cha[i] = cha; c_chb[i] = chb;
    endtask

    task automatic run(input int slot, input int cyc, input bit st);
        @(negedge clk);
        cur_slot = SLOT_W'(slot); cyc_cnt = CW'(cyc); static_seg = st; start = 1;
        @(negedge clk);
        start = 0;
        repeat (N + 1) @(negedge clk);
    endtask

    initial begin
        clear_cfg();
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", int'(done), 0);
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "found in reset", int'(a_found | b_found), 0);
        chk("R1", "err in reset", int'(cons_err), 0);
        rst = 0;
        @(negedge clk);
        chk("R1", "idx after reset", int'(a_idx) + int'(b_idx), 0);

        // R6: priority then lowest index
        cur_req = "R6";
        set_buf(1, 5, 0, 3, 0, 0, 0, 1, 0);
        set_buf(4, 5, 0, 1, 0, 0, 0, 1, 0);
        set_buf(7, 5, 0, 1, 0, 0, 0, 1, 0);
        set_buf(9, 5, 0, 2, 0, 0, 0, 1, 0);
        set_buf(3, 6, 0, 0, 0, 0, 0, 1, 0);
        run(5, 0, 0);
        chk("R6", "tie lowest idx", int'(a_idx), 4);
        chk("R6", "no B candidate", int'(b_found), 0);

        // R4 / R3: value-mask filter against an unfiltered buffer
        clear_cfg();
        cur_req = "R4";
        set_buf(2, 8, 0, 0, 1, 3, 2, 1, 0);
        set_buf(5, 8, 0, 5, 0, 0, 0, 1, 0);
        run(8, 6, 0);
        chk("R4", "filter hit cyc6", int'(a_idx), 2);
        run(8, 62, 0);
        chk("R4", "filter hit cyc62", int'(a_idx), 2);
        cur_req = "R3";
        run(8, 7, 0);
        chk("R3", "unfiltered wins cyc7", int'(a_idx), 5);
        run(8, 63, 0);
        chk("R3", "unfiltered cyc63", int'(a_idx), 5);

        // R5: disabled and wrong slot
        clear_cfg();
        cur_req = "R5";
        set_buf(0, 8, 0, 0, 0, 0, 0, 1, 1); c_en[0] = 0;
        set_buf(1, 9, 0, 0, 0, 0, 0, 1, 1);
        set_buf(6, 8, 0, 7, 0, 0, 0, 1, 1);
        run(8, 0, 0);
        chk("R5", "skip disabled/other slot", int'(a_idx), 6);
        c_en[6] = 0;
        run(8, 0, 0);
        chk("R5", "nothing found", int'(a_found | b_found), 0);

        // R7: per-channel search, dual buffer wins both
        clear_cfg();
        cur_req = "R7";
        set_buf(2, 3, 0, 2, 0, 0, 0, 1, 0);
        set_buf(5, 3, 0, 1, 0, 0, 0, 0, 1);
        run(3, 0, 0);
        chk("R7", "A idx", int'(a_idx), 2);
        chk("R7", "B idx", int'(b_idx), 5);
        set_buf(8, 3, 0, 0, 0, 0, 0, 1, 1);
        run(3, 0, 0);
        chk("R7", "dual on A", int'(a_idx), 8);
        chk("R7", "dual on B", int'(b_idx), 8);

        // R8: static null-frame claim
        clear_cfg();
        cur_req = "R8";
        set_buf(1, 2, 1, 0, 1, 1, 0, 1, 0);
        set_buf(3, 2, 0, 1, 0, 0, 0, 1, 0);
        run(2, 1, 1);
        chk("R8", "static tx claims", int'(a_idx), 1);
        chk("R8", "null flag", int'(a_null), 1);
        run(2, 1, 0);
        chk("R8", "dynamic excludes", int'(a_idx), 3);
        chk("R8", "no null", int'(a_null), 0);
        c_tx[1] = 0;
        run(2, 1, 1);
        chk("R8", "static rx excluded", int'(a_idx), 3);
        run(2, 0, 1);
        chk("R8", "filter hit no null", int'(a_null), 0);

        // R9: mixed channel assignment at winning priority
        clear_cfg();
        cur_req = "R9";
        set_buf(0, 4, 0, 1, 0, 0, 0, 1, 0);
        set_buf(1, 4, 0, 1, 0, 0, 0, 1, 1);
        run(4, 0, 0);
        chk("R9", "mix flagged", int'(cons_err), 1);
        c_prio[1] = 2;
        run(4, 0, 0);
        chk("R9", "no mix", int'(cons_err), 0);

        // R2: start while busy ignored
        clear_cfg();
        cur_req = "R2";
        set_buf(3, 10, 0, 0, 0, 0, 0, 1, 0);
        set_buf(9, 11, 0, 0, 0, 0, 0, 1, 0);
        @(negedge clk);
        cur_slot = 10; start = 1;
        @(negedge clk);
        start = 0;
        repeat (4) @(negedge clk);
        cur_slot = 11; start = 1;
        @(negedge clk);
        start = 0;
        repeat (N) @(negedge clk);
        chk("R2", "second start ignored", int'(a_idx), 3);

        // R10: context captured at start
        cur_req = "R10";
        @(negedge clk);
        cur_slot = 11; start = 1;
        @(negedge clk);
        start = 0; cur_slot = 10;
        repeat (N + 1) @(negedge clk);
        chk("R10", "slot latched", int'(a_idx), 9);

        // pseudo-random mixes
        cur_req = "R6";
        begin
            int unsigned seed;
            seed = 32'h1234_5678;
            for (int t = 0; t < 40; t++) begin
                for (int i = 0; i < N; i++) begin
                    seed = seed * 1103515245 + 12345;
                    c_en[i] = seed[20]; c_slot[i] = SLOT_W'(seed[17:16]);
                    c_tx[i] = seed[21]; c_prio[i] = PRIO_W'(seed[23:22]);
                    c_cfe[i] = seed[24]; c_mask[i] = CW'(seed[30:25]); c_val[i] = CW'(seed[11:6]);
                    c_cha[i] = seed[12]; c_chb[i] = seed[13];
                end
                seed = seed * 1103515245 + 12345;
                run(int'(seed[17:16]), int'(seed[25:20]), seed[27]);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog run did not end actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule